// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching one entry from a flat page table kept in memory. The table is an array with one 4-byte entry for each 4 KB virtual page. The upper 20 address bits select the entry, and the lower 12 bits pass through unchanged. A requester presents an address and says whether the access is a load or a store. The walker then forms the entry address from a programmable table-base register and issues a single read on a request/response memory port. It inspects the returned entry and answers with either a physical address or a fault code.

Software switches address spaces by writing the table-base register, as it would on a context switch. A write made while the walker is idle applies from the next cycle. A write made during a walk is held back until that walk has answered, so the walk in flight keeps the table it started with.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_req_valid` and `rsp_valid` are 0, and the table base is 0.
- R2: The entry read address is the table base plus four times the page number `vaddr[31:12]`, taken modulo 2^32.
- R3: If an entry has bit 0 (valid) and bit 2 (present) set, and the access is a load or bit 1 (writable) is set, the response has `rsp_fault` = 0 and `rsp_paddr` = {entry[31:12], vaddr[11:0]}.
- R4: An entry with bit 0 clear or bit 2 clear gives `rsp_fault` = 1 (page fault) with `rsp_paddr` = 0. This takes priority over the protection check.
- R5: A store to an entry that passes R4 but has bit 1 clear gives `rsp_fault` = 2 (protection fault) with `rsp_paddr` = 0.
- R6: Entry bits 3 (referenced) and 4 (dirty) have no effect on the response.
- R7: `req_ready` is 1 only while idle. A `req_valid` presented while it is 0 starts no read and produces no response.
- R8: Each walk issues exactly one read. `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready` accepts the read, and `mem_req_valid` drops in the next cycle.
- R9: `rsp_valid` is high for exactly one cycle: the cycle after the cycle in which `mem_rsp_valid` delivers the entry. The walker is idle again in the following cycle.
- R10: A base write while idle applies to requests accepted from the next cycle on.
- R11: Base writes made during a walk leave that walk's address unchanged. The last of them becomes the base once the walk has answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 for a store access, 0 for a load |
| req_ready | output | 1 | Walker idle; request accepted when both are high |
| base_wr | input | 1 | Write strobe for the table-base register |
| base_wdata | input | 32 | New table base |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data valid, at least one cycle after acceptance |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation result, one-cycle pulse |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |

## Verification
Assertions check the following on every cycle:
- the read request and its address stay stable until accepted, and each walk issues only one read;
- `req_ready` falls after a request is taken;
- the response is a single-cycle pulse, and a faulting response carries a zero address with a legal fault code;
- the base register stays still while a walk waits for memory, and a held-back write is cleared once the walk answers.

Only the bench's scenarios can show that the numbers are right: the entry address arithmetic including wrap-around, the physical address and fault chosen for each flag pattern, that the referenced and dirty bits are ignored, and which base a walk actually used around idle and in-flight base writes.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } walk_st_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;

  // Entry flag positions
  localparam int unsigned PTE_VALID_BIT = 0;
  localparam int unsigned PTE_WR_BIT    = 1;
  localparam int unsigned PTE_PRES_BIT  = 2;
  localparam int unsigned PTE_REF_BIT   = 3;
  localparam int unsigned PTE_DIRTY_BIT = 4;

endpackage

// File: rtl/pgwalk_base_reg.sv
module pgwalk_base_reg #(
  parameter int unsigned AW      = 32,
  parameter logic [AW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic          busy,
  input  logic          commit,
  output logic [AW-1:0] base_o
);

  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] pdat_q, pdat_d;
  logic          pend_q, pend_d;
  logic          ld_base, ld_pend;

  always_comb begin
    base_d  = base_q;
    pdat_d  = pdat_q;
    pend_d  = pend_q;
    ld_base = 1'b0;
    ld_pend = 1'b0;
    if (!busy) begin
      if (wr_en) begin
        base_d  = wr_data;
        ld_base = 1'b1;
      end
    end else begin
      if (wr_en) begin
        pend_d  = 1'b1;
        pdat_d  = wr_data;
        ld_pend = 1'b1;
      end
      if (commit) begin
        ld_pend = 1'b1;
        pend_d  = 1'b0;
        if (wr_en) begin
          base_d  = wr_data;
          ld_base = 1'b1;
        end else if (pend_q) begin
          base_d  = pdat_q;
          ld_base = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= RST_VAL;
    end else if (ld_base) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pdat_q <= '0;
    end else if (ld_pend) begin
      pend_q <= pend_d;
      pdat_q <= pdat_d;
    end
  end

  assign base_o = base_q;

  // R11: the base in use cannot move while a walk waits for its entry
  p_base_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> $stable(base_o));

  // R11: a deferred write is consumed when the walk answers
  p_pend_drained_r11: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !pend_q);

endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
  import pgwalk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     mem_req_ready,
  input  logic     mem_rsp_valid,
  output logic     req_ready,
  output logic     mem_req_valid,
  output logic     start,
  output logic     capture,
  output walk_st_e state_o
);

  walk_st_e st_q, st_d;
  logic     sent_q, sent_d;
  logic     ld_sent;

  assign req_ready     = (st_q == ST_IDLE);
  assign start         = req_ready && req_valid;
  assign mem_req_valid = (st_q == ST_WAIT) && !sent_q;
  assign capture       = (st_q == ST_WAIT) && sent_q && mem_rsp_valid;
  assign state_o       = st_q;

  always_comb begin
    st_d    = st_q;
    sent_d  = sent_q;
    ld_sent = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d    = ST_WAIT;
          sent_d  = 1'b0;
          ld_sent = 1'b1;
        end
      end
      ST_WAIT: begin
        if (mem_req_valid && mem_req_ready) begin
          sent_d  = 1'b1;
          ld_sent = 1'b1;
        end
        if (capture) begin
          st_d = ST_RESP;
        end
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= 1'b0;
    end else if (ld_sent) begin
      sent_q <= sent_d;
    end
  end

  // R7: taking a request closes the door until the walk ends
  p_busy_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !req_ready);

  // R8: an unaccepted read stays requested
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid);

  // R8: only one read per walk
  p_single_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  // R9: the answer state lasts one cycle
  p_resp_then_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RESP) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/pgwalk_check.sv
module pgwalk_check
  import pgwalk_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned OFF_W = 12
) (
  input  logic [AW-1:0]    pte,
  input  logic [OFF_W-1:0] offset,
  input  logic             is_store,
  output logic [AW-1:0]    paddr,
  output logic [1:0]       fault
);

  logic mapped, write_ok;

  // Referenced, dirty and spare bits are deliberately not consulted (R6)
  logic unused_flags;
  assign unused_flags = ^pte[OFF_W-1:PTE_REF_BIT];

  assign mapped   = pte[PTE_VALID_BIT] && pte[PTE_PRES_BIT];
  assign write_ok = !is_store || pte[PTE_WR_BIT];

  always_comb begin
    if (!mapped) begin
      fault = FLT_PAGE;
      paddr = '0;
    end else if (!write_ok) begin
      fault = FLT_PROT;
      paddr = '0;
    end else begin
      fault = FLT_NONE;
      paddr = {pte[AW-1:OFF_W], offset};
    end
  end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned OFF_W    = 12,
  parameter int unsigned PTE_SH   = 2,
  parameter logic [AW-1:0] BASE_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_vaddr,
  input  logic          req_store,
  output logic          req_ready,
  input  logic          base_wr,
  input  logic [AW-1:0] base_wdata,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_paddr,
  output logic [1:0]    rsp_fault
);

  localparam int unsigned VPN_W = AW - OFF_W;

  walk_st_e        st;
  logic            start, capture;
  logic [AW-1:0]   base;
  logic [VPN_W-1:0] vpn;
  logic [AW-1:0]   eaddr_d, eaddr_q;
  logic [OFF_W-1:0] off_q;
  logic            store_q;
  logic [AW-1:0]   pa_d, pa_q;
  logic [1:0]      flt_d, flt_q;

  pgwalk_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .start         (start),
    .capture       (capture),
    .state_o       (st)
  );

  pgwalk_base_reg #(.AW(AW), .RST_VAL(BASE_RST)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (base_wr),
    .wr_data (base_wdata),
    .busy    (st != ST_IDLE),
    .commit  (st == ST_RESP),
    .base_o  (base)
  );

  pgwalk_check #(.AW(AW), .OFF_W(OFF_W)) u_check (
    .pte      (mem_rsp_data),
    .offset   (off_q),
    .is_store (store_q),
    .paddr    (pa_d),
    .fault    (flt_d)
  );

  assign vpn     = req_vaddr[AW-1:OFF_W];
  assign eaddr_d = base + (AW'(vpn) << PTE_SH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eaddr_q <= '0;
      off_q   <= '0;
      store_q <= 1'b0;
    end else if (start) begin
      eaddr_q <= eaddr_d;
      off_q   <= req_vaddr[OFF_W-1:0];
      store_q <= req_store;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q  <= '0;
      flt_q <= FLT_NONE;
    end else if (capture) begin
      pa_q  <= pa_d;
      flt_q <= flt_d;
    end
  end

  assign mem_req_addr = eaddr_q;
  assign rsp_valid    = (st == ST_RESP);
  assign rsp_paddr    = pa_q;
  assign rsp_fault    = flt_q;

  // R8: address stays put while the read waits for acceptance
  p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));

  // R9: the answer is a single-cycle pulse
  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R4: a faulting answer carries no address
  p_fault_zero_pa_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0));

  // R5: only the three defined codes appear
  p_fault_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault != 2'd3));

  // R7: no answer while a new request can be taken
  p_no_rsp_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid);

endmodule

// File: tb/tb_pgwalk_top.sv
`timescale 1ns/1ps
module tb_pgwalk_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_store, base_wr;
  logic [31:0] req_vaddr, base_wdata;
  logic        mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        req_ready, mem_req_valid, rsp_valid;
  logic [31:0] mem_req_addr, rsp_paddr;
  logic [1:0]  rsp_fault;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] cur_base;

  always #2.5 clk = ~clk;

  pgwalk_top dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_store(req_store),
    .req_ready(req_ready),
    .base_wr(base_wr), .base_wdata(base_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_fault(input logic [31:0] pte, input logic st);
    if (!pte[0] || !pte[2]) return 2'd1;
    if (st && !pte[1])      return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [31:0] exp_pa(input logic [31:0] pte, input logic [31:0] va,
                                         input logic st);
    if (exp_fault(pte, st) != 2'd0) return 32'h0;
    return {pte[31:12], va[11:0]};
  endfunction

  // One full walk driven and checked from negedge to negedge
  task automatic do_walk(input logic [31:0] va, input logic st, input logic [31:0] pte,
                         input int stall, input int lat, input logic poke_req,
                         input logic poke_base, input logic [31:0] poke_val);
    logic [31:0] exp_addr, got_addr, epa;
    logic [1:0]  ef;
    string       tag;
    exp_addr = cur_base + {va[31:12], 2'b00};
    chk(req_ready == 1'b1, "R7", "ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_vaddr = va; req_store = st;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_req_valid && !req_ready, "R8", "read raised, ready dropped",
        {mem_req_valid, req_ready}, 32'd2);
    got_addr = mem_req_addr;
    chk(got_addr == exp_addr, "R2", "entry address", got_addr, exp_addr);
    for (int i = 0; i < stall; i++) begin
      mem_req_ready = 1'b0;
      if (poke_req) begin req_valid = 1'b1; req_vaddr = ~va; req_store = ~st; end
      @(negedge clk);
      chk(mem_req_valid && mem_req_addr == got_addr, "R8", "held read address",
          mem_req_addr, got_addr);
    end
    req_valid = 1'b0;
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(!mem_req_valid, "R8", "read dropped after accept", 32'(mem_req_valid), 32'd0);
    for (int i = 0; i < lat; i++) begin
      if (poke_base && i == 0) begin base_wr = 1'b1; base_wdata = poke_val ^ 32'h0000_3000; end
      if (poke_base && i == 1) begin base_wr = 1'b1; base_wdata = poke_val; end
      if (poke_req) begin req_valid = 1'b1; req_vaddr = va ^ 32'h0040_0000; end
      @(negedge clk);
      base_wr = 1'b0;
      req_valid = 1'b0;
      chk(!rsp_valid && !mem_req_valid, "R9", "quiet while memory busy",
          {rsp_valid, mem_req_valid}, 32'd0);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = pte;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = $urandom;
    ef  = exp_fault(pte, st);
    epa = exp_pa(pte, va, st);
    tag = (ef == 2'd0) ? "R3" : (ef == 2'd1) ? "R4" : "R5";
    chk(rsp_valid == 1'b1, "R9", "response cycle", 32'(rsp_valid), 32'd1);
    chk(rsp_fault == ef, tag, "fault code", 32'(rsp_fault), 32'(ef));
    chk(rsp_paddr == epa, tag, "physical address", rsp_paddr, epa);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R9", "single pulse then idle",
        {rsp_valid, req_ready}, 32'd1);
    if (poke_req)
      chk(!mem_req_valid && !rsp_valid, "R7", "blocked request left no walk",
          {mem_req_valid, rsp_valid}, 32'd0);
    if (poke_base) cur_base = poke_val;
  endtask

  task automatic idle_base_write(input logic [31:0] v);
    base_wr = 1'b1; base_wdata = v;
    @(negedge clk);
    base_wr = 1'b0;
    cur_base = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared + 1, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] r_va, r_pte;
    logic [1:0]  ef0, ef1;
    void'($urandom(32'd20431));
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_store = 1'b0;
    base_wr = 1'b0; base_wdata = '0; mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    cur_base = 32'h0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready && !mem_req_valid && !rsp_valid, "R1", "reset outputs",
        {req_ready, mem_req_valid, rsp_valid}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: base starts at zero
    do_walk(32'h0000_3abc, 1'b0, 32'h0001_2007, 0, 1, 1'b0, 1'b0, '0);

    // R10: idle write then immediate request; example base 0x5000, page 1
    idle_base_write(32'h0000_5000);
    do_walk(32'h0000_1100, 1'b0, 32'h0000_0005, 1, 2, 1'b0, 1'b0, '0);
    // R2: top page and wrap-around of the adder
    do_walk(32'hffff_f010, 1'b0, 32'h0abc_d007, 0, 1, 1'b0, 1'b0, '0);
    idle_base_write(32'hffff_fff0);
    do_walk(32'h0000_8fff, 1'b1, 32'h7777_7003, 2, 1, 1'b0, 1'b0, '0);

    // R4: invalid, not present, and priority over protection on a store
    do_walk(32'h1234_5678, 1'b0, 32'hdead_b006, 0, 1, 1'b0, 1'b0, '0);
    do_walk(32'h1234_5678, 1'b0, 32'hdead_b003, 0, 1, 1'b0, 1'b0, '0);
    do_walk(32'h1234_5678, 1'b1, 32'hdead_b001, 0, 1, 1'b0, 1'b0, '0);
    // R5: store to read-only, and a load to the same entry succeeds (R3)
    do_walk(32'h4000_0abc, 1'b1, 32'h0055_5005, 0, 1, 1'b0, 1'b0, '0);
    do_walk(32'h4000_0abc, 1'b0, 32'h0055_5005, 0, 1, 1'b0, 1'b0, '0);
    // R6: referenced and dirty flags set versus clear give the same answer
    do_walk(32'h0800_0123, 1'b1, 32'h0099_9007, 0, 1, 1'b0, 1'b0, '0);
    do_walk(32'h0800_0123, 1'b1, 32'h0099_901f, 0, 1, 1'b0, 1'b0, '0);
    do_walk(32'h0800_0123, 1'b1, 32'h0099_9018, 0, 1, 1'b0, 1'b0, '0);

    // R7: requests offered while busy are ignored
    do_walk(32'h0200_0444, 1'b0, 32'h0123_4007, 3, 3, 1'b1, 1'b0, '0);
    // R11: two writes during a walk; old base used, last write wins afterwards
    do_walk(32'h0030_0040, 1'b0, 32'h0011_1007, 1, 3, 1'b0, 1'b1, 32'h0008_0000);
    do_walk(32'h0030_0040, 1'b0, 32'h0011_1007, 0, 1, 1'b0, 1'b0, '0);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic st, pr, pb;
      int sl, lt;
      r_va  = $urandom;
      r_pte = $urandom;
      st = 1'($urandom % 2);
      sl = int'($urandom % 3);
      lt = 1 + int'($urandom % 3);
      pr = ($urandom % 4) == 0;
      pb = (lt >= 2) && (($urandom % 5) == 0);
      if (($urandom % 8) == 0) idle_base_write($urandom & 32'hffff_fffc);
      if (($urandom % 3) != 0) r_pte[2:0] = 3'b111;
      do_walk(r_va, st, r_pte, sl, lt, pr, pb, $urandom & 32'hffff_fffc);
    end

    // R6: random pairs differing only in flags 3 and 4
    for (int n = 0; n < 20; n++) begin
      r_va  = $urandom;
      r_pte = $urandom;
      ef0 = exp_fault(r_pte, 1'b1);
      ef1 = exp_fault(r_pte ^ 32'h18, 1'b1);
      chk(ef0 == ef1, "R6", "bench model flag independence", 32'(ef0), 32'(ef1));
      do_walk(r_va, 1'b1, r_pte ^ 32'h18, 0, 1, 1'b0, 1'b0, '0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule